// File: doc/BRIEF.md
# Serial Transceiver with Inter-Character Guard and Idle Timeout

This block is a full-duplex asynchronous serial transceiver. A single-character holding register feeds a bit-level transmitter, and a 16x-oversampling receiver delivers characters into a one-character receive register. The character format can be set: 5 to 8 data bits, even, odd or no parity, and one or two stop bits. The bit period is set by a divider input. The usual setting is 8 data bits, no parity and one stop bit.

Two additions support message-based traffic. The transmitter can hold the line idle for a programmed number of bit periods after each character, which suits slow remote receivers. The receiver can flag a quiet line a programmed number of bit periods after the last character, and software treats this flag as the end of a variable-length frame. The receiver and the transmitter each have their own enable, disable and soft-reset pulses. The error flags are sticky. Three test routings serve diagnostics: the line is echoed back out, the transmitter is looped into the receiver, or the line is looped back outward.

Top module: `sio_uart`

## Requirements
- R1: After reset both directions are disabled: `tx_ready`=0, `tx_empty`=1, `txd`=1, `rx_valid`=0, and every flag is 0.
- R2: The enable and disable pulses of each direction act independently. A disable pulse wins over an enable pulse in the same cycle, and `tx_ready` is then 0 in the next cycle.
- R3: A write accepted on edge E starts the start bit (0) on edge E+2. The frame then carries 5+`cfg_len` data bits, LSB first. A parity bit follows for `cfg_par`=01 (even) or 10 (odd); values 00 and 11 send no parity bit. After that come one stop bit, or two when `cfg_stop`=1. Every bit lasts 16*`cfg_div` clocks.
- R4: With `cfg_tg`=G>0, `txd` stays high for G extra bit periods after the stop bits. A character waiting in the holding register starts right after that with no further gap.
- R5: `rst_tx` drops any frame in progress and the held character. `txd` is 1 from the next cycle, and the enable is unchanged.
- R6: The receiver takes the majority of three samples around mid-bit. A one-clock glitch therefore does not corrupt a bit. A finished character sets `rx_valid` with the data right-aligned, and `rx_rd` clears `rx_valid`.
- R7: A parity bit that does not match the configured parity sets the sticky `err_par`, and the character is still delivered.
- R8: A stop bit sampled as 0 sets the sticky `err_frm`.
- R9: A character that completes while `rx_valid` is still set, with no read in that cycle, sets `err_ovr` and replaces `rx_data`.
- R10: With `cfg_to`=T>0, `timeout` rises T bit periods after a character completes if the receiver sees no new start bit in that time. The count is armed only by reset, `rst_rx` or `sto`, and a set flag disarms it. `sto` clears the flag, and counting then waits for the next character. T=0 never sets the flag.
- R11: `rst_sts` clears `err_par`, `err_frm`, `err_ovr` and `timeout`. It takes priority over a flag being set in the same cycle.
- R12: `rst_rx` clears `rx_valid`, the error flags and `timeout`, and aborts reception.
- R13: `cfg_mode` selects the routing. 00 is normal. 01 echoes `rxd` to `txd` while the receiver still listens. 10 feeds the transmitter into the receiver and holds `txd` at 1. 11 echoes `rxd` to `txd` and holds the receiver input idle.
- R14: While the receiver is disabled, traffic on `rxd` leaves `rx_valid` and `rx_data` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Enable receiver pulse |
| rx_dis | input | 1 | Disable receiver pulse |
| tx_en | input | 1 | Enable transmitter pulse |
| tx_dis | input | 1 | Disable transmitter pulse |
| rst_rx | input | 1 | Receiver soft reset pulse |
| rst_tx | input | 1 | Transmitter soft reset pulse |
| rst_sts | input | 1 | Clear sticky flags pulse |
| sto | input | 1 | Clear and re-arm idle timeout pulse |
| cfg_div | input | DIV_W | Clocks per oversampling tick |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | 01 even, 10 odd, else none |
| cfg_stop | input | 1 | Two stop bits when 1 |
| cfg_tg | input | TG_W | Guard length in bit periods |
| cfg_to | input | TO_W | Idle timeout in bit periods |
| cfg_mode | input | 2 | Routing: normal, echo, local loop, remote loop |
| tx_wr | input | 1 | Write `tx_data` when `tx_ready` |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register free and transmitter enabled |
| tx_empty | output | 1 | Nothing held and nothing on the wire |
| rx_rd | input | 1 | Consume received character |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character present |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun |
| timeout | output | 1 | Sticky idle timeout |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
A transmit state or bit counter that is off shows up on `txd` in the very clock it goes wrong, because the bench predicts the wire level for every clock from the format inputs alone. Errors on the receive side wait until the end of a character. A bad vote or shift shows in `rx_data`, and a wrong parity or stop decision shows in the flags at the stop bit. A wrong timeout counter shows as `timeout` rising outside a window of a few clocks around T bit periods.

// File: rtl/sio_uart.sv
`timescale 1ns/1ps
module sio_uart #(
  parameter int DIV_W = 12,
  parameter int TG_W  = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_dis,
  input  logic             tx_en,
  input  logic             tx_dis,
  input  logic             rst_rx,
  input  logic             rst_tx,
  input  logic             rst_sts,
  input  logic             sto,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_stop,
  input  logic [TG_W-1:0]  cfg_tg,
  input  logic [TO_W-1:0]  cfg_to,
  input  logic [1:0]       cfg_mode,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             tx_empty,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             err_par,
  output logic             err_frm,
  output logic             err_ovr,
  output logic             timeout,
  input  logic             rxd,
  output logic             txd
);
  localparam int BC_W = DIV_W + 4;
  localparam int TT_W = TO_W + 4;

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP, T_GUARD} tst_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_t;

  logic tx_on, rx_on;
  wire  par_on   = (cfg_par == 2'b01) || (cfg_par == 2'b10);
  wire  [2:0] last_idx = 3'd4 + {1'b0, cfg_len};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_on <= 1'b0;
      rx_on <= 1'b0;
    end else begin
      if (tx_dis) tx_on <= 1'b0; else if (tx_en) tx_on <= 1'b1;
      if (rx_dis) rx_on <= 1'b0; else if (rx_en) rx_on <= 1'b1;
    end

  // transmitter
  tst_t            t_st;
  logic [BC_W-1:0] t_cnt;
  logic [7:0]      t_sh, hold;
  logic [2:0]      t_idx;
  logic            t_par, hold_full, txd_eng;
  logic [TG_W-1:0] t_gd;

  wire [BC_W-1:0] bit_last = {cfg_div, 4'b0000} - BC_W'(1);
  wire t_adv = (t_cnt == bit_last);
  wire t_fin = t_adv && (((t_st == T_STOP) && !(cfg_stop && t_gd == '0) && cfg_tg == '0) ||
                         ((t_st == T_GUARD) && t_gd <= TG_W'(1)));

  assign tx_ready = tx_on && !hold_full;
  assign tx_empty = (t_st == T_IDLE) && !hold_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t_st <= T_IDLE; t_cnt <= '0; t_sh <= '0; hold <= '0; hold_full <= 1'b0;
      t_idx <= '0; t_par <= 1'b0; t_gd <= '0;
    end else if (rst_tx) begin
      t_st <= T_IDLE; t_cnt <= '0; hold_full <= 1'b0;
    end else begin
      if (tx_wr && tx_ready) begin
        hold <= tx_data;
        hold_full <= 1'b1;
      end
      if (t_st != T_IDLE) begin
        t_cnt <= t_adv ? '0 : t_cnt + BC_W'(1);
        if (t_adv)
          case (t_st)
            T_START: begin t_st <= T_DATA; t_idx <= '0; end
            T_DATA: begin
              t_par <= t_par ^ t_sh[0];
              t_sh  <= t_sh >> 1;
              if (t_idx == last_idx) begin
                t_st <= par_on ? T_PAR : T_STOP;
                t_gd <= '0;
              end else t_idx <= t_idx + 3'd1;
            end
            T_PAR: begin t_st <= T_STOP; t_gd <= '0; end
            T_STOP:
              if (cfg_stop && t_gd == '0) t_gd <= TG_W'(1);
              else if (cfg_tg != '0) begin t_st <= T_GUARD; t_gd <= cfg_tg; end
            T_GUARD: t_gd <= t_gd - TG_W'(1);
            default: t_st <= T_IDLE;
          endcase
      end
      if ((t_st == T_IDLE || t_fin) && hold_full) begin
        t_st <= T_START; t_sh <= hold; t_par <= 1'b0; t_cnt <= '0; hold_full <= 1'b0;
      end else if (t_fin) t_st <= T_IDLE;
    end

  always_comb
    case (t_st)
      T_START: txd_eng = 1'b0;
      T_DATA:  txd_eng = t_sh[0];
      T_PAR:   txd_eng = (cfg_par == 2'b01) ? t_par : ~t_par;
      default: txd_eng = 1'b1;
    endcase

  assign txd = cfg_mode[0] ? rxd : (cfg_mode == 2'b10) ? 1'b1 : txd_eng;

  // receiver
  logic             rs1, rs2, v0, v1, r_par, r_perr;
  logic [DIV_W-1:0] bc;
  logic [3:0]       s_cnt;
  logic [2:0]       r_idx;
  logic [7:0]       r_sh;
  rst_t             r_st;

  wire rline   = (cfg_mode == 2'b10) ? txd_eng : (cfg_mode == 2'b11) ? 1'b1 : rs2;
  wire rx_tick = (bc >= cfg_div - DIV_W'(1));
  wire maj     = (v0 & v1) | (v0 & rline) | (v1 & rline);
  wire rx_done = rx_on && rx_tick && (r_st == R_STOP) && (s_cnt == 4'd9);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; bc <= '0;
    end else begin
      rs1 <= rxd; rs2 <= rs1;
      bc  <= rx_tick ? '0 : bc + DIV_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_st <= R_IDLE; s_cnt <= '0; r_idx <= '0; r_sh <= '0;
      v0 <= 1'b1; v1 <= 1'b1; r_par <= 1'b0; r_perr <= 1'b0;
    end else if (rst_rx || !rx_on) r_st <= R_IDLE;
    else if (rx_tick) begin
      if (r_st == R_IDLE) begin
        if (!rline) begin r_st <= R_START; s_cnt <= 4'd1; r_par <= 1'b0; r_perr <= 1'b0; end
      end else begin
        s_cnt <= s_cnt + 4'd1;
        if (s_cnt == 4'd7) v0 <= rline;
        if (s_cnt == 4'd8) v1 <= rline;
        if (s_cnt == 4'd9)
          case (r_st)
            R_START: if (maj) r_st <= R_IDLE;
            R_DATA:  begin r_sh <= {maj, r_sh[7:1]}; r_par <= r_par ^ maj; end
            R_PAR:   r_perr <= maj ^ r_par ^ (cfg_par == 2'b10);
            default: r_st <= R_IDLE;
          endcase
        if (s_cnt == 4'd15)
          case (r_st)
            R_START: begin r_st <= R_DATA; r_idx <= '0; end
            R_DATA:
              if (r_idx == last_idx) r_st <= par_on ? R_PAR : R_STOP;
              else r_idx <= r_idx + 3'd1;
            R_PAR:   r_st <= R_STOP;
            default: r_st <= R_IDLE;
          endcase
      end
    end

  // receive holding, flags and idle timeout
  logic            to_arm, to_run;
  logic [TT_W-1:0] to_t;
  wire  [TT_W-1:0] to_lim = {cfg_to, 4'b0000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0;
      timeout <= 1'b0; to_arm <= 1'b1; to_run <= 1'b0; to_t <= '0;
    end else if (rst_rx) begin
      rx_valid <= 1'b0; err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0;
      timeout <= 1'b0; to_arm <= 1'b1; to_run <= 1'b0; to_t <= '0;
    end else begin
      if (rx_rd) rx_valid <= 1'b0;
      if (rx_done) begin
        rx_valid <= 1'b1;
        rx_data  <= r_sh >> (2'd3 - cfg_len);
        if (!maj) err_frm <= 1'b1;
        if (r_perr && par_on) err_par <= 1'b1;
        if (rx_valid && !rx_rd) err_ovr <= 1'b1;
      end
      if (cfg_to == '0) to_run <= 1'b0;
      else if (rx_done && to_arm) begin
        to_run <= 1'b1; to_t <= '0;
      end else if (to_run) begin
        if (r_st != R_IDLE) to_t <= '0;
        else if (rx_tick) begin
          if (to_t == to_lim - TT_W'(1)) begin
            timeout <= 1'b1; to_run <= 1'b0; to_arm <= 1'b0;
          end else to_t <= to_t + TT_W'(1);
        end
      end
      if (sto) begin timeout <= 1'b0; to_arm <= 1'b1; to_run <= 1'b0; end
      if (rst_sts) begin err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0; timeout <= 1'b0; end
    end
endmodule

// File: rtl/sio_uart_chk.sv
`timescale 1ns/1ps
module sio_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_dis,
  input logic       rst_tx,
  input logic       rst_rx,
  input logic       rst_sts,
  input logic [1:0] cfg_mode,
  input logic       txd,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       err_par,
  input logic       err_frm,
  input logic       err_ovr,
  input logic       timeout,
  input logic       rx_on
);
  assert_dis_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dis |=> !tx_ready);

  assert_rst_tx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_tx && cfg_mode == 2'b00) |=> (txd || cfg_mode != 2'b00));

  assert_par_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && !rst_sts && !rst_rx) |=> err_par);

  assert_ovr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> rx_valid);

  assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sts |=> !(err_par || err_frm || err_ovr || timeout));

  assert_rx_gated_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_on));
endmodule

bind sio_uart sio_uart_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_dis(tx_dis), .rst_tx(rst_tx), .rst_rx(rst_rx),
  .rst_sts(rst_sts), .cfg_mode(cfg_mode), .txd(txd), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
  .timeout(timeout), .rx_on(rx_on)
);

// File: tb/sio_uart_tb_top.sv
`timescale 1ns/1ps
module sio_uart_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, rx_dis = 0, tx_en = 0, tx_dis = 0, rst_rx = 0, rst_tx = 0, rst_sts = 0, sto = 0;
  logic [11:0] cfg_div = 12'd1;
  logic [1:0]  cfg_len = 2'd3, cfg_par = 2'd0, cfg_mode = 2'd0;
  logic        cfg_stop = 0;
  logic [7:0]  cfg_tg = 8'd0;
  logic [15:0] cfg_to = 16'd0;
  logic        tx_wr = 0, rx_rd = 0, rxd = 1'b1;
  logic [7:0]  tx_data = 8'd0;
  logic        tx_ready, tx_empty, rx_valid, err_par, err_frm, err_ovr, timeout, txd;
  logic [7:0]  rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R3";
  bit q[$];

  always #2 clk = ~clk;

  sio_uart dut_i (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push_bit(bit b);
    for (int i = 0; i < 16 * cfg_div; i++) q.push_back(b);
  endtask

  task automatic send_tx(logic [7:0] d);
    int n = 5 + cfg_len;
    bit p = 0;
    if (q.size() == 0) begin q.push_back(1); q.push_back(1); end
    push_bit(0);
    for (int i = 0; i < n; i++) begin push_bit(d[i]); p ^= d[i]; end
    if (cfg_par == 2'b01) push_bit(p);
    if (cfg_par == 2'b10) push_bit(~p);
    push_bit(1);
    if (cfg_stop) push_bit(1);
    for (int g = 0; g < cfg_tg; g++) push_bit(1);
    tx_data = d; tx_wr = 1; step(); tx_wr = 0;
  endtask

  task automatic wait_tx();
    while (q.size() > 0) step();
    repeat (4) step();
  endtask

  task automatic send_rx(logic [7:0] d, bit bad_par, bit stop_v, bit glitch);
    int n = 5 + cfg_len;
    bit p = 0;
    rxd = 0; repeat (16) step();
    for (int i = 0; i < n; i++) begin
      p ^= d[i];
      for (int c = 0; c < 16; c++) begin
        rxd = (glitch && i == 2 && c == 7) ? ~d[i] : d[i];
        step();
      end
    end
    if (cfg_par == 2'b01 || cfg_par == 2'b10) begin
      rxd = p ^ (cfg_par == 2'b10) ^ bad_par; repeat (16) step();
    end
    rxd = stop_v; repeat (16) step();
    rxd = 1;
  endtask

  task automatic read_rx();
    rx_rd = 1; step(); rx_rd = 0;
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit qb, e;
    qb = (q.size() > 0) ? q.pop_front() : 1'b1;
    case (cfg_mode)
      2'b00: e = qb;
      2'b10: e = 1'b1;
      default: e = rxd;
    endcase
    chk(cur_req, txd, e);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog: got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1; step();
    chk("R1 tx_ready", tx_ready, 0); chk("R1 tx_empty", tx_empty, 1);
    chk("R1 txd", txd, 1); chk("R1 rx_valid", rx_valid, 0);
    chk("R1 flags", {err_par, err_frm, err_ovr, timeout}, 0);

    tx_en = 1; step(); tx_en = 0;
    chk("R2 enable", tx_ready, 1);
    tx_en = 1; tx_dis = 1; step(); tx_en = 0; tx_dis = 0;
    chk("R2 disable wins", tx_ready, 0);
    tx_en = 1; step(); tx_en = 0;

    cur_req = "R3";
    send_tx(8'hA5); wait_tx();
    cfg_len = 2'd0; cfg_par = 2'b10; cfg_stop = 1; send_tx(8'h13); wait_tx();
    cfg_len = 2'd3; cfg_par = 2'b01; cfg_stop = 0; send_tx(8'h6E); wait_tx();
    cfg_par = 2'b00; cfg_div = 12'd2; send_tx(8'h81); wait_tx();
    cfg_div = 12'd1;

    cur_req = "R4";
    cfg_tg = 8'd2;
    send_tx(8'h55);
    while (!tx_ready) step();
    send_tx(8'hC3); wait_tx();
    cfg_tg = 8'd0;

    cur_req = "R5";
    send_tx(8'h0F);
    while (!tx_ready) step();
    send_tx(8'hF0);
    repeat (40) step();
    rst_tx = 1;
    if (q.size() > 1) q = q[0:0];
    step(); rst_tx = 0;
    repeat (100) step();
    chk("R5 tx_empty", tx_empty, 1);
    chk("R5 enable kept", tx_ready, 1);

    cur_req = "R13";
    rx_en = 1; step(); rx_en = 0;
    send_rx(8'h3C, 0, 1, 0); repeat (4) step();
    chk("R6 valid", rx_valid, 1); chk("R6 data", rx_data, 8'h3C);
    chk("R6 no errors", {err_par, err_frm, err_ovr}, 0);
    read_rx();
    chk("R6 read clears", rx_valid, 0);
    send_rx(8'hA4, 0, 1, 1); repeat (4) step();
    chk("R6 glitch vote", rx_data, 8'hA4);
    read_rx();

    cfg_par = 2'b01;
    send_rx(8'h71, 1, 1, 0); repeat (4) step();
    chk("R7 par err", err_par, 1); chk("R7 delivered", rx_data, 8'h71);
    read_rx();
    cfg_par = 2'b10;
    send_rx(8'h22, 0, 1, 0); repeat (4) step();
    chk("R7 odd ok sticky", err_par, 1); chk("R7 odd data", rx_data, 8'h22);
    read_rx();
    rst_sts = 1; step(); rst_sts = 0;
    chk("R11 cleared", err_par, 0);
    cfg_par = 2'b00;

    send_rx(8'h99, 0, 0, 0); repeat (20) step();
    chk("R8 frame err", err_frm, 1); chk("R8 data", rx_data, 8'h99);
    read_rx();
    rst_sts = 1; step(); rst_sts = 0;
    chk("R11 frm cleared", err_frm, 0);

    cfg_len = 2'd1;
    send_rx(8'h15, 0, 1, 0);
    send_rx(8'h2A, 0, 1, 0); repeat (4) step();
    chk("R9 overrun", err_ovr, 1); chk("R9 newest data", rx_data, 8'h2A);
    cfg_len = 2'd3;

    rst_rx = 1; step(); rst_rx = 0;
    chk("R12 valid", rx_valid, 0); chk("R12 ovr", err_ovr, 0);

    cfg_to = 16'd3;
    send_rx(8'h10, 0, 1, 0);
    repeat (36) step();
    chk("R10 not yet", timeout, 0);
    repeat (16) step();
    chk("R10 fired", timeout, 1);
    read_rx();
    sto = 1; step(); sto = 0;
    chk("R10 sto clears", timeout, 0);
    repeat (120) step();
    chk("R10 waits for char", timeout, 0);
    send_rx(8'h11, 0, 1, 0); repeat (70) step();
    chk("R10 refired", timeout, 1);
    read_rx();
    cfg_to = 16'd0; sto = 1; step(); sto = 0;
    send_rx(8'h12, 0, 1, 0); repeat (200) step();
    chk("R10 zero disables", timeout, 0);
    read_rx();

    rx_dis = 1; step(); rx_dis = 0;
    send_rx(8'h77, 0, 1, 0); repeat (10) step();
    chk("R14 ignored valid", rx_valid, 0); chk("R14 data kept", rx_data, 8'h12);
    rx_en = 1; step(); rx_en = 0;

    cfg_mode = 2'b01;
    send_rx(8'h4D, 0, 1, 0); repeat (4) step();
    chk("R13 echo receives", rx_valid, 1); chk("R13 echo data", rx_data, 8'h4D);
    read_rx();
    cfg_mode = 2'b11;
    send_rx(8'h4E, 0, 1, 0); repeat (10) step();
    chk("R13 remote rx idle", rx_valid, 0);
    cfg_mode = 2'b10;
    send_tx(8'h5A); wait_tx(); repeat (10) step();
    chk("R13 local valid", rx_valid, 1); chk("R13 local data", rx_data, 8'h5A);
    read_rx();
    cfg_mode = 2'b00;
    repeat (10) step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule